// File: doc/BRIEF.md
# Loadable Shift Register with Serial Output

This block is an eight-stage shift register whose only output is the bit held in its last stage. On each rising edge of the clock, a mode input picks one of two actions. In shift mode, every stage takes the bit from the stage before it, and the first stage takes the serial data input. In load mode, all eight stages take the parallel input word in one step. A clock-inhibit input turns the register's clock enable off, so edges that arrive while it is high have no effect. An active-low clear zeroes every stage at once, without waiting for a clock edge, and overrides all other inputs.

A typical use is parallel-to-serial conversion. The host loads a word, then shifts it out over eight enabled edges, most significant parallel bit first. Serial data can also be passed straight through the register, which then acts as an eight-cycle delay line. The clear is asserted without a clock, but its release is synchronised to the clock. For this reason the register ignores the first two rising edges after clear is released.

Top module: `psio_shift_reg`

## Requirements
- R1: The register has eight stages, numbered 0 (first) to 7 (last), and `ser_out` always shows stage 7. After a load edge, `ser_out` equals `par_in[7]`.
- R2: On a rising edge with `clk_inhibit` low and `shift_nload` high, stage 0 takes `ser_in` and stage i takes stage i-1. After k such edges following a load, `ser_out` equals `par_in[7-k]` of the loaded word, and a serial bit reaches `ser_out` on the eighth shift edge after it entered.
- R3: Loading is synchronous. With `shift_nload` low, `par_in[i]` enters stage i only on a rising edge with `clk_inhibit` low. Changing `par_in` or `shift_nload` between edges leaves `ser_out` unchanged.
- R4: While `clk_inhibit` is high at a rising edge, all eight stages keep their contents, whatever `shift_nload`, `ser_in` and `par_in` do.
- R5: Driving `clr_n` low zeroes all stages at once, without a clock edge and at any point in the clock cycle, so `ser_out` goes to 0.
- R6: While `clr_n` is low, rising clock edges change nothing, whatever the other inputs do.
- R7: After `clr_n` returns high, the register stays at zero through the first two rising edges, and the third rising edge is the first that can load or shift.
- R8: `clk_inhibit` changes while `clk` is high, and only the level present at the rising edge decides whether that edge acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| clk_inhibit | input | 1 | High blocks the effect of clock edges |
| shift_nload | input | 1 | 1 = shift serial data in, 0 = parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel word; bit i loads stage i |
| clr_n | input | 1 | Active-low clear, asynchronous assertion |
| ser_out | output | 1 | Contents of stage 7 |

## Verification
Only one stage can be seen from outside, so the hardest thing to confirm is that the whole register held its value or was cleared, not just its last stage. The bench handles this by shifting a full word out after each inhibit window, each clear and each random stretch, and comparing every bit with a bench model. Clear is dropped at two points in the cycle: while the clock is high and while it is low. Each time, clock edges are applied while clear is held and again right after release, so the two-edge release delay is observed directly on `ser_out`.

// File: rtl/psio_pkg.sv
package psio_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } op_mode_e;
endpackage

// File: rtl/psio_clr_sync.sv
module psio_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

  // R6
  clr_hold_chk: assert property (@(posedge clk) !clr_n |-> !rst_n_out)
    else $error("internal reset released while clear held");
endmodule

// File: rtl/psio_next_state.sv
module psio_next_state
  import psio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_q,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  op_mode_e         mode,
  output logic [WIDTH-1:0] nxt_q
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      logic shift_src;
      if (gi == 0) begin : g_head
        assign shift_src = ser_in;
      end else begin : g_body
        assign shift_src = cur_q[gi-1];
      end
      always_comb begin
        nxt_q[gi] = (mode == MODE_SHIFT) ? shift_src : par_in[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/psio_stage_reg.sv
module psio_stage_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] nxt_q,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] d_q;

  always_comb begin
    d_q = en ? nxt_q : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d_q;
  end

  // R4
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q))
    else $error("stages changed while inhibited");

  // R5
  clear_zero_chk: assert property (@(posedge clk) !rst_n |-> (q == '0))
    else $error("stages not zero in reset");
endmodule

// File: rtl/psio_shift_reg.sv
module psio_shift_reg
  import psio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clk_inhibit,
  input  logic             shift_nload,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  input  logic             clr_n,
  output logic             ser_out
);
  localparam int LAST = WIDTH - 1;

  logic             rst_n_int;
  logic             clk_en;
  op_mode_e         mode;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_nxt;

  assign clk_en = ~clk_inhibit;
  assign mode   = op_mode_e'(shift_nload);

  psio_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .clr_n     (clr_n),
    .rst_n_out (rst_n_int)
  );

  psio_next_state #(.WIDTH(WIDTH)) u_next (
    .cur_q  (stage_q),
    .ser_in (ser_in),
    .par_in (par_in),
    .mode   (mode),
    .nxt_q  (stage_nxt)
  );

  psio_stage_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (clk_en),
    .nxt_q (stage_nxt),
    .q     (stage_q)
  );

  assign ser_out = stage_q[LAST];

  // R1 R3
  load_out_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clk_inhibit && !shift_nload) |=> (ser_out == $past(par_in[LAST])))
    else $error("load did not reach serial output");

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clk_inhibit && shift_nload) |=>
      (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}))
    else $error("shift step wrong");

  // R3
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clk_inhibit && !shift_nload) |=> (stage_q == $past(par_in)))
    else $error("parallel load wrong");
endmodule

// File: tb/tb_psio_shift_reg.sv
module tb_psio_shift_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clk_inhibit, shift_nload, ser_in, clr_n;
  logic [7:0] par_in;
  logic       ser_out;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  logic [7:0]  model;
  int          rel_cnt;
  logic        model_clr;

  psio_shift_reg dut (
    .clk(clk), .clk_inhibit(clk_inhibit), .shift_nload(shift_nload),
    .ser_in(ser_in), .par_in(par_in), .clr_n(clr_n), .ser_out(ser_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] step_model(logic [7:0] m, logic inh,
                                             logic sl, logic si, logic [7:0] p);
    if (inh) return m;
    if (sl)  return {m[6:0], si};
    return p;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at posedge+1 (clock high); drives inputs, waits one edge, checks.
  task automatic cycle(string req, logic inh, logic sl, logic si, logic [7:0] p);
    clk_inhibit = inh; shift_nload = sl; ser_in = si; par_in = p;
    @(posedge clk);
    if (model_clr) model = '0;
    else if (rel_cnt < 2) begin rel_cnt++; model = '0; end
    else model = step_model(model, inh, sl, si, p);
    #1;
    check(req, ser_out, model[7]);
  endtask

  task automatic drain(string req);
    for (int k = 0; k < 8; k++) cycle(req, 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clr_n = 1'b0; clk_inhibit = 1'b0; shift_nload = 1'b0;
    ser_in = 1'b0; par_in = 8'hFF;
    model = '0; rel_cnt = 0; model_clr = 1'b1;
    #1;
    check("R5 reset state", ser_out, 1'b0);
    @(posedge clk); #1;
    // R6: edges with clear low and load of all ones do nothing
    cycle("R6 clear held", 1'b0, 1'b0, 1'b1, 8'hFF);
    clr_n = 1'b1; model_clr = 1'b0; rel_cnt = 0;
    // R7: two ignored edges after release, third loads
    cycle("R7 release edge1", 1'b0, 1'b0, 1'b0, 8'hFF);
    cycle("R7 release edge2", 1'b0, 1'b0, 1'b0, 8'hFF);
    cycle("R7 release edge3", 1'b0, 1'b0, 1'b0, 8'hFF);

    // R1 R2: load and shift out MSB first
    cycle("R1 load B4", 1'b0, 1'b0, 1'b0, 8'hB4);
    for (int k = 0; k < 7; k++) cycle("R2 shift out", 1'b0, 1'b1, 1'b0, 8'h00);
    // R2: serial pattern passes through
    cycle("R1 load 00", 1'b0, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 8; k++)
      cycle("R2 serial in", 1'b0, 1'b1, logic'((8'hC9 >> k) & 1), 8'hFF);
    drain("R2 serial drain");

    // R3: changing inputs between edges leaves ser_out
    cycle("R1 load 7E", 1'b0, 1'b0, 1'b0, 8'h7E);
    shift_nload = 1'b0; par_in = 8'h80; #2;
    check("R3 no load before edge", ser_out, 1'b0);
    par_in = 8'h00; #1;
    check("R3 no load before edge", ser_out, 1'b0);
    @(posedge clk); #1;   // back in step: apply the load of 00 to model
    model = 8'h00;
    check("R3 load at edge", ser_out, 1'b0);

    // R4 R8: inhibit blocks loads and shifts, contents survive
    cycle("R1 load A5", 1'b0, 1'b0, 1'b0, 8'hA5);
    cycle("R4 inhibit load", 1'b1, 1'b0, 1'b1, 8'h00);
    cycle("R4 inhibit shift", 1'b1, 1'b1, 1'b0, 8'h00);
    cycle("R8 inhibit high at edge", 1'b1, 1'b0, 1'b0, 8'h5A);
    drain("R4 contents kept");

    // R5 R6 R7: clear while clock high
    cycle("R1 load FF", 1'b0, 1'b0, 1'b0, 8'hFF);
    #1 clr_n = 1'b0; model_clr = 1'b1; #1;
    check("R5 clear clock high", ser_out, 1'b0);
    @(posedge clk); #1;
    cycle("R6 clear held", 1'b0, 1'b0, 1'b0, 8'hFF);
    clr_n = 1'b1; model_clr = 1'b0; rel_cnt = 0;
    cycle("R7 release edge1", 1'b0, 1'b0, 1'b0, 8'hFF);
    cycle("R7 release edge2", 1'b0, 1'b1, 1'b1, 8'hFF);
    cycle("R7 release edge3", 1'b0, 1'b0, 1'b0, 8'hFF);
    // clear while clock low
    #5 clr_n = 1'b0; model_clr = 1'b1; #1;
    check("R5 clear clock low", ser_out, 1'b0);
    @(posedge clk); #1;
    clr_n = 1'b1; model_clr = 1'b0; rel_cnt = 0;
    cycle("R7 release edge1", 1'b0, 1'b0, 1'b0, 8'hFF);
    cycle("R7 release edge2", 1'b0, 1'b0, 1'b0, 8'hFF);
    drain("R5 all stages zero");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic inh;
      inh = (($urandom % 4) == 0);
      cycle("R2 R4 random", inh, logic'($urandom % 2), logic'($urandom % 2),
            8'($urandom));
    end
    drain("R4 random drain");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule